// File: doc/BRIEF.md
# Dynamic Shifter with T Flag

This block is the shift, rotate and permute execution unit of a 32-bit integer pipeline that keeps a single-bit T flag. Each cycle it takes a 5-bit operation code, two operands (`srcA`, the value operand, and `srcB`, the count or second operand) and the current T. One clock later it presents the result word and the new T on registered outputs.

Dynamic shifts take their direction from the sign of `srcB` and their distance from its low five bits. A negative count shifts right by the complement of those bits. A negative count whose low bits are all zero shifts out the whole word. Single-bit shifts and rotates send the bit that falls out into T. Fixed shifts by 2, 8 and 16 leave T alone. Three permutes swap the low two bytes, swap the halfwords, or join halves of two registers.

The register file and instruction decode sit outside the block. The caller feeds T back in on the next operation.

Top module: `dynshf_unit`

## Requirements
- R1: While `rst_n` is low, `result` reads 0 and `tOut` reads 0.
- R2: For codes 0 (arithmetic dynamic) and 1 (logical dynamic), when `srcB[31]` is 0, `result` is `srcA` shifted left by `srcB[4:0]` with zero fill, and `tOut` equals `tIn`.
- R3: For codes 0 and 1, when `srcB[31]` is 1 and `srcB[4:0]` is nonzero, `result` is `srcA` shifted right by 32 − `srcB[4:0]`. Code 0 fills with the sign bit and code 1 fills with zeros. `tOut` equals `tIn`.
- R4: For codes 0 and 1, when `srcB[31]` is 1 and `srcB[4:0]` is zero, code 0 gives all ones if `srcA[31]` is 1 and zero otherwise. Code 1 always gives zero.
- R5: Code 2 shifts `srcA` left by one with bit 0 cleared and `tOut` = old bit 31. Code 3 (logical) and code 4 (arithmetic) shift right by one: code 3 clears bit 31, code 4 keeps the sign bit, and `tOut` = old bit 0.
- R6: Code 5 rotates left by one and code 6 rotates right by one. The bit that leaves the word re-enters at the opposite end and is also copied to `tOut`.
- R7: Code 7 rotates left through T: bit 0 takes `tIn` and `tOut` takes old bit 31. Code 8 rotates right through T: bit 31 takes `tIn` and `tOut` takes old bit 0.
- R8: Codes 9, 10 and 11 shift left by 2, 8 and 16. Codes 12, 13 and 14 shift right logically by 2, 8 and 16. In all six `tOut` equals `tIn`.
- R9: Code 15 gives `{srcA[31:16], srcA[7:0], srcA[15:8]}` with `tOut` = `tIn`.
- R10: Code 16 gives `{srcA[15:0], srcA[31:16]}` with `tOut` = `tIn`.
- R11: Code 17 gives `{srcA[15:0], srcB[31:16]}` with `tOut` = `tIn`.
- R12: Codes 18 to 31 have no effect: `result` equals `srcA` and `tOut` equals `tIn`.
- R13: The outputs change only at a rising clock edge. They reflect the inputs present at that edge and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opCode | input | 5 | Operation code (0–17 defined) |
| srcA | input | 32 | Value operand; first operand of extract |
| srcB | input | 32 | Dynamic count, or second operand of extract |
| tIn | input | 1 | Current T flag |
| result | output | 32 | Registered result word |
| tOut | output | 1 | Registered new T flag |

## Verification
The properties assume that the operation code, operands and T are stable, known values at every rising edge once reset has been released. They also assume that no output is expected in the cycle in which reset falls. The stimulus changes inputs only on falling edges and keeps every input at a defined value from time zero, including during reset. It reads the outputs on the falling edge after the capturing rising edge. Both dynamic-count boundaries are driven: a negative count with zero low bits, and a large positive count with zero low bits.

// File: rtl/dynshf_pkg.sv
package dynshf_pkg;

  typedef enum logic [4:0] {
    OP_DSHA  = 5'd0,
    OP_DSHL  = 5'd1,
    OP_SHL1  = 5'd2,
    OP_SHR1  = 5'd3,
    OP_SAR1  = 5'd4,
    OP_ROL   = 5'd5,
    OP_ROR   = 5'd6,
    OP_RCL   = 5'd7,
    OP_RCR   = 5'd8,
    OP_SHL2  = 5'd9,
    OP_SHL8  = 5'd10,
    OP_SHL16 = 5'd11,
    OP_SHR2  = 5'd12,
    OP_SHR8  = 5'd13,
    OP_SHR16 = 5'd14,
    OP_SWPB  = 5'd15,
    OP_SWPH  = 5'd16,
    OP_XTR   = 5'd17
  } shfOp_e;

  typedef enum logic [2:0] {
    RES_SHIFT,
    RES_SWPB,
    RES_SWPH,
    RES_XTR,
    RES_PASS
  } resSel_e;

  typedef enum logic [2:0] {
    AMT_DYN,
    AMT_1,
    AMT_2,
    AMT_8,
    AMT_16
  } amtSel_e;

  typedef enum logic [1:0] {
    FILL_ZERO,
    FILL_SIGN,
    FILL_WRAP,
    FILL_TBIT
  } fill_e;

  typedef enum logic [1:0] {
    T_KEEP,
    T_MSB,
    T_LSB
  } tSel_e;

  typedef struct packed {
    resSel_e resSel;
    amtSel_e amtSel;
    logic    goRight;
    fill_e   fill;
    tSel_e   tSel;
  } shfCtl_t;

endpackage

// File: rtl/dynshf_ctrl.sv
module dynshf_ctrl
  import dynshf_pkg::*;
(
  input  logic [4:0] opCode,
  output shfCtl_t    ctl
);

  always_comb begin
    ctl = '{resSel: RES_PASS, amtSel: AMT_1, goRight: 1'b0,
            fill: FILL_ZERO, tSel: T_KEEP};
    case (opCode)
      OP_DSHA:  begin ctl.resSel = RES_SHIFT; ctl.amtSel = AMT_DYN; ctl.fill = FILL_SIGN; end
      OP_DSHL:  begin ctl.resSel = RES_SHIFT; ctl.amtSel = AMT_DYN; end
      OP_SHL1:  begin ctl.resSel = RES_SHIFT; ctl.tSel = T_MSB; end
      OP_SHR1:  begin ctl.resSel = RES_SHIFT; ctl.goRight = 1'b1; ctl.tSel = T_LSB; end
      OP_SAR1:  begin ctl.resSel = RES_SHIFT; ctl.goRight = 1'b1; ctl.fill = FILL_SIGN;
                      ctl.tSel = T_LSB; end
      OP_ROL:   begin ctl.resSel = RES_SHIFT; ctl.fill = FILL_WRAP; ctl.tSel = T_MSB; end
      OP_ROR:   begin ctl.resSel = RES_SHIFT; ctl.goRight = 1'b1; ctl.fill = FILL_WRAP;
                      ctl.tSel = T_LSB; end
      OP_RCL:   begin ctl.resSel = RES_SHIFT; ctl.fill = FILL_TBIT; ctl.tSel = T_MSB; end
      OP_RCR:   begin ctl.resSel = RES_SHIFT; ctl.goRight = 1'b1; ctl.fill = FILL_TBIT;
                      ctl.tSel = T_LSB; end
      OP_SHL2:  begin ctl.resSel = RES_SHIFT; ctl.amtSel = AMT_2; end
      OP_SHL8:  begin ctl.resSel = RES_SHIFT; ctl.amtSel = AMT_8; end
      OP_SHL16: begin ctl.resSel = RES_SHIFT; ctl.amtSel = AMT_16; end
      OP_SHR2:  begin ctl.resSel = RES_SHIFT; ctl.amtSel = AMT_2;  ctl.goRight = 1'b1; end
      OP_SHR8:  begin ctl.resSel = RES_SHIFT; ctl.amtSel = AMT_8;  ctl.goRight = 1'b1; end
      OP_SHR16: begin ctl.resSel = RES_SHIFT; ctl.amtSel = AMT_16; ctl.goRight = 1'b1; end
      OP_SWPB:  ctl.resSel = RES_SWPB;
      OP_SWPH:  ctl.resSel = RES_SWPH;
      OP_XTR:   ctl.resSel = RES_XTR;
      default:  ctl.resSel = RES_PASS;
    endcase
  end

endmodule

// File: rtl/dynshf_barrel.sv
module dynshf_barrel #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  logic              goRight,
  input  logic              fillBit,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] stage [0:AMT_W];

  assign stage[0] = din;

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    logic [DATA_W-1:0] rightVal;
    logic [DATA_W-1:0] leftVal;
    assign rightVal = {{STEP{fillBit}}, stage[i][DATA_W-1:STEP]};
    assign leftVal  = {stage[i][DATA_W-1-STEP:0], {STEP{1'b0}}};
    assign stage[i+1] = amt[i] ? (goRight ? rightVal : leftVal) : stage[i];
  end

  assign dout = stage[AMT_W];

endmodule

// File: rtl/dynshf_datapath.sv
module dynshf_datapath
  import dynshf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  shfCtl_t           ctl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              tIn,
  output logic [DATA_W-1:0] resNext,
  output logic              tNext
);

  localparam int AMT_W = $clog2(DATA_W);
  localparam int HALF  = DATA_W / 2;
  localparam int BYTE  = 8;

  logic              cntNeg;
  logic [AMT_W-1:0]  cntLow;
  logic              fullOut;
  logic              dirRight;
  logic [AMT_W-1:0]  amt;
  logic              signFill;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] shiftRes;
  logic              insertBit;
  logic              doInsert;

  assign cntNeg  = srcB[DATA_W-1];
  assign cntLow  = srcB[AMT_W-1:0];
  assign fullOut = (ctl.amtSel == AMT_DYN) && cntNeg && (cntLow == '0);

  always_comb begin
    dirRight = ctl.goRight;
    case (ctl.amtSel)
      AMT_DYN: begin
        dirRight = cntNeg;
        amt      = cntNeg ? AMT_W'(DATA_W - int'(cntLow)) : cntLow;
      end
      AMT_2:   amt = AMT_W'(2);
      AMT_8:   amt = AMT_W'(8);
      AMT_16:  amt = AMT_W'(16);
      default: amt = AMT_W'(1);
    endcase
  end

  assign signFill = (ctl.fill == FILL_SIGN) && srcA[DATA_W-1];

  dynshf_barrel #(.DATA_W(DATA_W)) u_barrel (
    .din     (srcA),
    .amt     (amt),
    .goRight (dirRight),
    .fillBit (signFill),
    .dout    (shifted)
  );

  always_comb begin
    doInsert  = 1'b0;
    insertBit = 1'b0;
    if (ctl.amtSel == AMT_1) begin
      if (ctl.fill == FILL_WRAP) begin
        doInsert  = 1'b1;
        insertBit = ctl.goRight ? srcA[0] : srcA[DATA_W-1];
      end else if (ctl.fill == FILL_TBIT) begin
        doInsert  = 1'b1;
        insertBit = tIn;
      end
    end
  end

  always_comb begin
    shiftRes = shifted;
    if (fullOut) begin
      shiftRes = {DATA_W{signFill}};
    end else if (doInsert) begin
      if (ctl.goRight) shiftRes[DATA_W-1] = insertBit;
      else             shiftRes[0]        = insertBit;
    end
  end

  always_comb begin
    case (ctl.resSel)
      RES_SHIFT: resNext = shiftRes;
      RES_SWPB:  resNext = {srcA[DATA_W-1:2*BYTE], srcA[BYTE-1:0], srcA[2*BYTE-1:BYTE]};
      RES_SWPH:  resNext = {srcA[HALF-1:0], srcA[DATA_W-1:HALF]};
      RES_XTR:   resNext = {srcA[HALF-1:0], srcB[DATA_W-1:HALF]};
      default:   resNext = srcA;
    endcase
  end

  always_comb begin
    case (ctl.tSel)
      T_MSB:   tNext = srcA[DATA_W-1];
      T_LSB:   tNext = srcA[0];
      default: tNext = tIn;
    endcase
  end

endmodule

// File: rtl/dynshf_unit.sv
module dynshf_unit
  import dynshf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              tIn,
  output logic [DATA_W-1:0] result,
  output logic              tOut
);

  shfCtl_t           ctl;
  logic [DATA_W-1:0] resNext;
  logic              tNext;

  dynshf_ctrl u_ctrl (
    .opCode (opCode),
    .ctl    (ctl)
  );

  dynshf_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctl     (ctl),
    .srcA    (srcA),
    .srcB    (srcB),
    .tIn     (tIn),
    .resNext (resNext),
    .tNext   (tNext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      tOut   <= 1'b0;
    end else begin
      result <= resNext;
      tOut   <= tNext;
    end
  end

endmodule

// File: rtl/dynshf_checker.sv
module dynshf_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        opCode,
  input logic [DATA_W-1:0] srcA,
  input logic [DATA_W-1:0] srcB,
  input logic              tIn,
  input logic [DATA_W-1:0] result,
  input logic              tOut
);

  localparam int AMT_W = $clog2(DATA_W);
  localparam int HALF  = DATA_W / 2;

  a_r8_fixed_keeps_t: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode >= 5'd9 && opCode <= 5'd14) |=> tOut == $past(tIn));

  a_r12_undef_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode >= 5'd18) |=> (result == $past(srcA)) && (tOut == $past(tIn)));

  a_r4_logical_full_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 5'd1 && srcB[DATA_W-1] && srcB[AMT_W-1:0] == '0) |=> result == '0);

  a_r5_left_msb_to_t: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 5'd2) |=> (tOut == $past(srcA[DATA_W-1])) && !result[0]);

  a_r6_rotl_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 5'd5) |=> result == {$past(srcA[DATA_W-2:0]), $past(srcA[DATA_W-1])});

  a_r10_half_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 5'd16) |=> result == {$past(srcA[HALF-1:0]), $past(srcA[DATA_W-1:HALF])});

  a_r2_dyn_keeps_t: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode <= 5'd1) |=> tOut == $past(tIn));

endmodule

bind dynshf_unit dynshf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .opCode (opCode),
  .srcA   (srcA),
  .srcB   (srcB),
  .tIn    (tIn),
  .result (result),
  .tOut   (tOut)
);

// File: tb/sim_dynshf_unit.sv
`timescale 1ns/100ps
module sim_dynshf_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  opCode = 5'd0;
  logic [31:0] srcA = 32'h0;
  logic [31:0] srcB = 32'h0;
  logic        tIn = 1'b0;
  logic [31:0] result;
  logic        tOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dynshf_unit u0 (
    .clk(clk), .rst_n(rst_n), .opCode(opCode), .srcA(srcA),
    .srcB(srcB), .tIn(tIn), .result(result), .tOut(tOut)
  );

  localparam logic [31:0] VA = 32'h8765_4321;
  localparam logic [31:0] VB = 32'h1234_5678;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic t);
    @(negedge clk);
    opCode = op; srcA = a; srcB = b; tIn = t;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_op(input string req, input logic [4:0] op, input logic [31:0] a,
                           input logic [31:0] b, input logic t,
                           input logic [31:0] expRes, input logic expT);
    run(op, a, b, t);
    check({req, " result"}, result, expRes);
    check({req, " T"}, {31'b0, tOut}, {31'b0, expT});
  endtask

  task automatic t_reset;
    opCode = 5'd16; srcA = VA; srcB = VB; tIn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset result", result, 32'h0);
    check("R1 reset T", {31'b0, tOut}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_dynLeft;
    expect_op("R2 dyn left 4",       5'd0, VA, 32'd4,        1'b1, 32'h7654_3210, 1'b1);
    expect_op("R2 dyn left 0",       5'd1, VA, 32'd0,        1'b0, VA,            1'b0);
    expect_op("R2 dyn left 31",      5'd1, VA, 32'd31,       1'b1, 32'h8000_0000, 1'b1);
    expect_op("R2 dyn pos low zero", 5'd0, VA, 32'h7FFF_FFE0, 1'b0, VA,           1'b0);
  endtask

  task automatic t_dynRight;
    expect_op("R3 dyn arith right 4", 5'd0, VA, 32'hFFFF_FFFC, 1'b1, 32'hF876_5432, 1'b1);
    expect_op("R3 dyn logic right 4", 5'd1, VA, 32'hFFFF_FFFC, 1'b0, 32'h0876_5432, 1'b0);
    expect_op("R3 dyn logic right 31", 5'd1, VA, 32'hFFFF_FFE1, 1'b0, 32'h0000_0001, 1'b0);
  endtask

  task automatic t_dynFull;
    expect_op("R4 arith full neg",  5'd0, VA, 32'hFFFF_FFE0, 1'b0, 32'hFFFF_FFFF, 1'b0);
    expect_op("R4 arith full pos",  5'd0, VB, 32'hFFFF_FFE0, 1'b1, 32'h0,         1'b1);
    expect_op("R4 logic full neg",  5'd1, VA, 32'h8000_0000, 1'b0, 32'h0,         1'b0);
  endtask

  task automatic t_singleShift;
    expect_op("R5 shl1",       5'd2, VA, 32'h0, 1'b0, 32'h0ECA_8642, 1'b1);
    expect_op("R5 shl1 t0",    5'd2, VB, 32'h0, 1'b1, 32'h2468_ACF0, 1'b0);
    expect_op("R5 shr1 logic", 5'd3, VA, 32'h0, 1'b0, 32'h43B2_A190, 1'b1);
    expect_op("R5 shr1 arith", 5'd4, VA, 32'h0, 1'b0, 32'hC3B2_A190, 1'b1);
  endtask

  task automatic t_rotate;
    expect_op("R6 rotl",      5'd5, VA, 32'h0, 1'b0, 32'h0ECA_8643, 1'b1);
    expect_op("R6 rotr",      5'd6, VA, 32'h0, 1'b0, 32'hC3B2_A190, 1'b1);
    expect_op("R6 rotl zero", 5'd5, VB, 32'h0, 1'b1, 32'h2468_ACF0, 1'b0);
  endtask

  task automatic t_rotThruT;
    expect_op("R7 rcl t0", 5'd7, VA, 32'h0, 1'b0, 32'h0ECA_8642, 1'b1);
    expect_op("R7 rcl t1", 5'd7, VB, 32'h0, 1'b1, 32'h2468_ACF1, 1'b0);
    expect_op("R7 rcr t0", 5'd8, VA, 32'h0, 1'b0, 32'h43B2_A190, 1'b1);
    expect_op("R7 rcr t1", 5'd8, VB, 32'h0, 1'b1, 32'h891A_2B3C, 1'b0);
  endtask

  task automatic t_fixed;
    expect_op("R8 shl2",  5'd9,  VA, 32'h0, 1'b1, 32'h1D95_0C84, 1'b1);
    expect_op("R8 shl8",  5'd10, VA, 32'h0, 1'b0, 32'h6543_2100, 1'b0);
    expect_op("R8 shl16", 5'd11, VA, 32'h0, 1'b1, 32'h4321_0000, 1'b1);
    expect_op("R8 shr2",  5'd12, VA, 32'h0, 1'b0, 32'h21D9_50C8, 1'b0);
    expect_op("R8 shr8",  5'd13, VA, 32'h0, 1'b1, 32'h0087_6543, 1'b1);
    expect_op("R8 shr16", 5'd14, VA, 32'h0, 1'b0, 32'h0000_8765, 1'b0);
  endtask

  task automatic t_permute;
    expect_op("R9 byte swap",  5'd15, VA, VB, 1'b1, 32'h8765_2143, 1'b1);
    expect_op("R10 half swap", 5'd16, VA, VB, 1'b0, 32'h4321_8765, 1'b0);
    expect_op("R11 extract",   5'd17, VA, VB, 1'b1, 32'h4321_1234, 1'b1);
  endtask

  task automatic t_undef;
    expect_op("R12 undef 18", 5'd18, VA, VB, 1'b1, VA, 1'b1);
    expect_op("R12 undef 31", 5'd31, VB, VA, 1'b0, VB, 1'b0);
  endtask

  task automatic t_latency;
    run(5'd16, VA, VB, 1'b0);
    @(negedge clk);
    opCode = 5'd15; srcA = VB; tIn = 1'b1;
    #1;
    check("R13 hold before edge", result, 32'h4321_8765);
    check("R13 T hold before edge", {31'b0, tOut}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R13 update after edge", result, 32'h1234_7856);
    check("R13 T update after edge", {31'b0, tOut}, 32'h1);
  endtask

  initial begin
    t_reset();
    t_dynLeft();
    t_dynRight();
    t_dynFull();
    t_singleShift();
    t_rotate();
    t_rotThruT();
    t_fixed();
    t_permute();
    t_undef();
    t_latency();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule